// File: doc/BRIEF.md
# Register-Register Integer ALU with Shifter

This block is the combinational execute unit for the register-register integer operations of a small RISC core. It receives two 32-bit operands, a 5-bit constant shift amount taken from the instruction and the instruction's 6-bit function code. In the same cycle it returns a 32-bit result and a signed-overflow flag. Operand fetch, immediate extension, decode of the major opcode and write-back belong to the surrounding pipeline.

The function code selects one of three paths: a shared adder/subtractor that also produces the set-less-than results, a bitwise logic unit, and a logarithmic barrel shifter. For constant shifts the amount comes from the shift-amount input. For variable shifts it comes from the low bits of operand A. Any function code outside the supported set gives a zero result.

Top module: `alu_rr_core`

## Requirements
- R1: Function code 100000 (signed add) and 100001 (unsigned add) both return (A + B) modulo 2^32.
- R2: Function code 100010 (signed subtract) and 100011 (unsigned subtract) both return (A - B) modulo 2^32.
- R3: The overflow output is high only for code 100000 when A and B have the same sign and the sum's sign differs, or for code 100010 when A and B have different signs and the difference's sign differs from A. Every other code, including 100001 and 100011, keeps it low.
- R4: Code 101010 returns 1 when A is less than B compared as two's-complement numbers, otherwise 0.
- R5: Code 101011 returns 1 when A is less than B compared as unsigned numbers, otherwise 0.
- R6: Code 100100 returns A AND B. Code 100101 returns A OR B.
- R7: Code 100110 returns A XOR B. Code 100111 returns NOT (A OR B).
- R8: Codes 000000, 000010 and 000011 shift B by the shift-amount input: left with zero fill, right with zero fill, and right with copies of B's bit 31, in that order.
- R9: Codes 000100, 000110 and 000111 shift B left logical, right logical and right arithmetic by A[4:0]. Bits 31..5 of A have no effect on the result.
- R10: Arithmetic right shifts (000011, 000111) fill the vacated upper bits with B's bit 31, so a negative B stays negative.
- R11: Any code not listed in R1 to R9 gives a result of zero with overflow low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 32 | First operand; the low 5 bits give the amount for variable shifts |
| op_b_i | input | 32 | Second operand; the data that all shifts move |
| shamt_i | input | 5 | Constant shift amount taken from the instruction |
| func_i | input | 6 | Function code selecting the operation |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow for signed add and subtract |

## Verification
The hardest cases to reach are at the edges of the adder: signed overflow at exactly the most positive and most negative values, and compares where signed and unsigned order disagree. Random operands almost never land there. The bench therefore drives fixed pairs such as 0x7FFFFFFF+1, 0x80000000-1 and 0xFFFFFFFF against 0x00000001, and applies each pair under the signed and the unsigned code. Variable shifts are driven with garbage in A's upper bits, so that an amount decoded from too many bits changes the result.

// File: rtl/alu_rr_pkg.sv
package alu_rr_pkg;

  localparam logic [5:0] FN_SLL  = 6'b000000;
  localparam logic [5:0] FN_SRL  = 6'b000010;
  localparam logic [5:0] FN_SRA  = 6'b000011;
  localparam logic [5:0] FN_SLLV = 6'b000100;
  localparam logic [5:0] FN_SRLV = 6'b000110;
  localparam logic [5:0] FN_SRAV = 6'b000111;
  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_ADDU = 6'b100001;
  localparam logic [5:0] FN_SUB  = 6'b100010;
  localparam logic [5:0] FN_SUBU = 6'b100011;
  localparam logic [5:0] FN_AND  = 6'b100100;
  localparam logic [5:0] FN_OR   = 6'b100101;
  localparam logic [5:0] FN_XOR  = 6'b100110;
  localparam logic [5:0] FN_NOR  = 6'b100111;
  localparam logic [5:0] FN_SLT  = 6'b101010;
  localparam logic [5:0] FN_SLTU = 6'b101011;

  typedef enum logic [2:0] {
    PATH_NONE,
    PATH_ARITH,
    PATH_CMP_S,
    PATH_CMP_U,
    PATH_LOGIC,
    PATH_SHIFT
  } alu_path_e;

  function automatic logic fn_known(input logic [5:0] f);
    case (f)
      FN_SLL, FN_SRL, FN_SRA, FN_SLLV, FN_SRLV, FN_SRAV,
      FN_ADD, FN_ADDU, FN_SUB, FN_SUBU, FN_AND, FN_OR,
      FN_XOR, FN_NOR, FN_SLT, FN_SLTU: fn_known = 1'b1;
      default:                         fn_known = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_en,
  output logic [WIDTH-1:0] sum,
  output logic             ovf_signed,
  output logic             lt_signed,
  output logic             lt_unsigned
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_x;
  logic [WIDTH:0]   full;

  always_comb begin
    b_x  = sub_en ? ~op_b : op_b;
    full = {1'b0, op_a} + {1'b0, b_x} + {{WIDTH{1'b0}}, sub_en};
    sum  = full[MSB:0];
    ovf_signed  = (op_a[MSB] == b_x[MSB]) && (full[MSB] != op_a[MSB]);
    lt_signed   = full[MSB] ^ ovf_signed;
    lt_unsigned = ~full[WIDTH];
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    case (sel)
      2'b00:   res = op_a & op_b;
      2'b01:   res = op_a | op_b;
      2'b10:   res = op_a ^ op_b;
      default: res = ~(op_a | op_b);
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data,
  input  logic [SHW-1:0]   amt,
  input  logic             left,
  input  logic             arith,
  output logic [WIDTH-1:0] res
);
  logic [WIDTH-1:0] v;

  always_comb begin
    v = data;
    for (int k = 0; k < SHW; k++) begin
      if (amt[k]) begin
        if (left)       v = v << (1 << k);
        else if (arith) v = $signed(v) >>> (1 << k);
        else            v = v >> (1 << k);
      end
    end
    res = v;
  end
endmodule

// File: rtl/alu_rr_core.sv
module alu_rr_core #(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [5:0]       func_i,
  output logic [WIDTH-1:0] result_o,
  output logic             ovf_o
);
  import alu_rr_pkg::*;

  alu_path_e        path;
  logic             ovf_chk;
  logic [WIDTH-1:0] sum, lres, sres;
  logic             ovf_s, lt_s, lt_u;
  logic [SHW-1:0]   amt;

  always_comb begin
    path    = PATH_NONE;
    ovf_chk = 1'b0;
    case (func_i)
      FN_ADD, FN_SUB:                     begin path = PATH_ARITH; ovf_chk = 1'b1; end
      FN_ADDU, FN_SUBU:                   path = PATH_ARITH;
      FN_SLT:                             path = PATH_CMP_S;
      FN_SLTU:                            path = PATH_CMP_U;
      FN_AND, FN_OR, FN_XOR, FN_NOR:      path = PATH_LOGIC;
      FN_SLL, FN_SRL, FN_SRA,
      FN_SLLV, FN_SRLV, FN_SRAV:          path = PATH_SHIFT;
      default:                            path = PATH_NONE;
    endcase
  end

  assign amt = func_i[2] ? op_a_i[SHW-1:0] : shamt_i;

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .op_a       (op_a_i),
    .op_b       (op_b_i),
    .sub_en     (func_i[1]),
    .sum        (sum),
    .ovf_signed (ovf_s),
    .lt_signed  (lt_s),
    .lt_unsigned(lt_u)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op_a(op_a_i),
    .op_b(op_b_i),
    .sel (func_i[1:0]),
    .res (lres)
  );

  alu_shifter #(.WIDTH(WIDTH)) u_shift (
    .data (op_b_i),
    .amt  (amt),
    .left (~func_i[1]),
    .arith(func_i[0]),
    .res  (sres)
  );

  always_comb begin
    case (path)
      PATH_ARITH: result_o = sum;
      PATH_CMP_S: result_o = {{(WIDTH-1){1'b0}}, lt_s};
      PATH_CMP_U: result_o = {{(WIDTH-1){1'b0}}, lt_u};
      PATH_LOGIC: result_o = lres;
      PATH_SHIFT: result_o = sres;
      default:    result_o = '0;
    endcase
    ovf_o = ovf_chk & ovf_s;
  end
endmodule

// File: rtl/alu_rr_checker.sv
module alu_rr_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [5:0]       func,
  input logic [WIDTH-1:0] result,
  input logic             ovf
);
  import alu_rr_pkg::*;

  always_comb begin
    if (!fn_known(func)) begin
      AST_UNKNOWN_ZERO: assert (result == '0 && !ovf); // R11
    end
    if (func != FN_ADD && func != FN_SUB) begin
      AST_NO_OVERFLOW: assert (!ovf); // R3
    end
    if (func == FN_ADD || func == FN_ADDU) begin
      AST_ADD_INVERTS: assert (result - op_b == op_a); // R1
    end
    if (func == FN_SUB || func == FN_SUBU) begin
      AST_SUB_INVERTS: assert (result + op_b == op_a); // R2
    end
    if (func == FN_SLT || func == FN_SLTU) begin
      AST_CMP_ONE_BIT: assert (result[WIDTH-1:1] == '0); // R4
    end
    if (func == FN_SRA || func == FN_SRAV) begin
      AST_SRA_SIGN_KEPT: assert (result[WIDTH-1] == op_b[WIDTH-1]); // R10
    end
  end
endmodule

bind alu_rr_core alu_rr_checker #(.WIDTH(WIDTH)) u_chk (
  .op_a  (op_a_i),
  .op_b  (op_b_i),
  .func  (func_i),
  .result(result_o),
  .ovf   (ovf_o)
);

// File: tb/alu_rr_core_tb.sv
module alu_rr_core_tb;
  logic        clk;
  logic [31:0] a, b;
  logic [4:0]  sh;
  logic [5:0]  fn;
  logic [31:0] res;
  logic        ovf;
  int          n_cmp = 0;
  int          n_bad = 0;

  alu_rr_core u_dut (
    .op_a_i  (a),
    .op_b_i  (b),
    .shamt_i (sh),
    .func_i  (fn),
    .result_o(res),
    .ovf_o   (ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] er, input logic eo);
    n_cmp++;
    if (res !== er || ovf !== eo) begin
      n_bad++;
      $display("FAIL %s fn=%b a=%h b=%h sh=%0d: got %h/%b exp %h/%b",
               tag, fn, a, b, sh, res, ovf, er, eo);
    end
  endtask

  task automatic apply(input logic [31:0] ia, input logic [31:0] ib,
                       input logic [4:0] ish, input logic [5:0] ifn);
    @(negedge clk);
    a = ia; b = ib; sh = ish; fn = ifn;
    #2;
  endtask

  function automatic logic [31:0] ref_res(input logic [31:0] x, input logic [31:0] y,
                                          input logic [4:0] s, input logic [5:0] f);
    case (f)
      6'b100000, 6'b100001: return x + y;
      6'b100010, 6'b100011: return x - y;
      6'b101010: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      6'b101011: return (x < y) ? 32'd1 : 32'd0;
      6'b100100: return x & y;
      6'b100101: return x | y;
      6'b100110: return x ^ y;
      6'b100111: return ~(x | y);
      6'b000000: return y << s;
      6'b000010: return y >> s;
      6'b000011: return $signed(y) >>> s;
      6'b000100: return y << x[4:0];
      6'b000110: return y >> x[4:0];
      6'b000111: return $signed(y) >>> x[4:0];
      default:   return 32'd0;
    endcase
  endfunction

  function automatic logic ref_ovf(input logic [31:0] x, input logic [31:0] y,
                                   input logic [5:0] f);
    logic [31:0] r;
    if (f == 6'b100000) begin
      r = x + y;
      return (x[31] == y[31]) && (r[31] != x[31]);
    end
    if (f == 6'b100010) begin
      r = x - y;
      return (x[31] != y[31]) && (r[31] != x[31]);
    end
    return 1'b0;
  endfunction

  task automatic run(input string tag, input logic [31:0] ia, input logic [31:0] ib,
                     input logic [4:0] ish, input logic [5:0] ifn);
    apply(ia, ib, ish, ifn);
    check(tag, ref_res(ia, ib, ish, ifn), ref_ovf(ia, ib, ifn));
  endtask

  task automatic t_idle;
    apply(32'd0, 32'd0, 5'd0, 6'b100000);
    check("R1 idle zero", 32'd0, 1'b0);
  endtask

  task automatic t_arith;
    run("R1 add", 32'd5, 32'd7, 5'd0, 6'b100000);
    apply(32'hFFFF_FFFF, 32'd1, 5'd0, 6'b100001);
    check("R1 addu wrap", 32'd0, 1'b0);
    apply(32'd3, 32'd5, 5'd0, 6'b100011);
    check("R2 subu wrap", 32'hFFFF_FFFE, 1'b0);
    for (int i = 0; i < 200; i++) begin
      run("R1 rand add", $urandom, $urandom, 5'd0, 6'b100000);
      run("R1 rand addu", $urandom, $urandom, 5'd0, 6'b100001);
      run("R2 rand sub", $urandom, $urandom, 5'd0, 6'b100010);
      run("R2 rand subu", $urandom, $urandom, 5'd0, 6'b100011);
    end
  endtask

  task automatic t_overflow;
    apply(32'h7FFF_FFFF, 32'd1, 5'd0, 6'b100000);
    check("R3 add pos ovf", 32'h8000_0000, 1'b1);
    apply(32'h7FFF_FFFF, 32'd1, 5'd0, 6'b100001);
    check("R3 addu no flag", 32'h8000_0000, 1'b0);
    apply(32'h8000_0000, 32'd1, 5'd0, 6'b100010);
    check("R3 sub neg ovf", 32'h7FFF_FFFF, 1'b1);
    apply(32'h8000_0000, 32'd1, 5'd0, 6'b100011);
    check("R3 subu no flag", 32'h7FFF_FFFF, 1'b0);
    apply(32'h8000_0000, 32'h8000_0000, 5'd0, 6'b100000);
    check("R3 add neg ovf", 32'd0, 1'b1);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 6'b100000);
    check("R3 add mixed no ovf", 32'h7FFF_FFFE, 1'b0);
    apply(32'h8000_0000, 32'h8000_0000, 5'd0, 6'b101010);
    check("R3 slt no flag", 32'd0, 1'b0);
  endtask

  task automatic t_compare;
    apply(32'hFFFF_FFFF, 32'd1, 5'd0, 6'b101010);
    check("R4 slt -1<1", 32'd1, 1'b0);
    apply(32'hFFFF_FFFF, 32'd1, 5'd0, 6'b101011);
    check("R5 sltu big", 32'd0, 1'b0);
    apply(32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 6'b101010);
    check("R4 slt min<max", 32'd1, 1'b0);
    apply(32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 6'b101011);
    check("R5 sltu min>max", 32'd0, 1'b0);
    apply(32'd9, 32'd9, 5'd0, 6'b101010);
    check("R4 slt equal", 32'd0, 1'b0);
    apply(32'd8, 32'd9, 5'd0, 6'b101011);
    check("R5 sltu less", 32'd1, 1'b0);
    for (int i = 0; i < 200; i++) begin
      run("R4 rand slt", $urandom, $urandom, 5'd0, 6'b101010);
      run("R5 rand sltu", $urandom, $urandom, 5'd0, 6'b101011);
    end
  endtask

  task automatic t_logic;
    apply(32'hF0F0_1234, 32'h0FF0_FFFF, 5'd0, 6'b100100);
    check("R6 and", 32'h00F0_1234, 1'b0);
    apply(32'hF0F0_1234, 32'h0FF0_0000, 5'd0, 6'b100101);
    check("R6 or", 32'hFFF0_1234, 1'b0);
    apply(32'hFFFF_0000, 32'hFF00_FF00, 5'd0, 6'b100110);
    check("R7 xor", 32'h00FF_FF00, 1'b0);
    apply(32'hFFFF_0000, 32'h0000_00FF, 5'd0, 6'b100111);
    check("R7 nor", 32'h0000_FF00, 1'b0);
    for (int i = 0; i < 100; i++) begin
      run("R6 rand and", $urandom, $urandom, 5'd0, 6'b100100);
      run("R6 rand or", $urandom, $urandom, 5'd0, 6'b100101);
      run("R7 rand xor", $urandom, $urandom, 5'd0, 6'b100110);
      run("R7 rand nor", $urandom, $urandom, 5'd0, 6'b100111);
    end
  endtask

  task automatic t_shift_const;
    apply(32'hDEAD_BEEF, 32'h0000_0001, 5'd31, 6'b000000);
    check("R8 sll 31", 32'h8000_0000, 1'b0);
    apply(32'd0, 32'h8000_0000, 5'd31, 6'b000010);
    check("R8 srl 31", 32'd1, 1'b0);
    apply(32'd0, 32'h8000_0000, 5'd31, 6'b000011);
    check("R10 sra 31", 32'hFFFF_FFFF, 1'b0);
    apply(32'd0, 32'h1234_5678, 5'd0, 6'b000011);
    check("R8 sra 0", 32'h1234_5678, 1'b0);
    for (int sv = 0; sv < 32; sv++) begin
      run("R8 sll", $urandom, $urandom, 5'(sv), 6'b000000);
      run("R8 srl", $urandom, $urandom, 5'(sv), 6'b000010);
      run("R10 sra", $urandom, $urandom | 32'h8000_0000, 5'(sv), 6'b000011);
    end
  endtask

  task automatic t_shift_var;
    apply(32'hFFFF_FFE4, 32'h0000_00F0, 5'd0, 6'b000100);
    check("R9 sllv upper A ignored", 32'h0000_0F00, 1'b0);
    apply(32'h0000_0FE4, 32'h0000_00F0, 5'd31, 6'b000110);
    check("R9 srlv upper A ignored", 32'h0000_000F, 1'b0);
    apply(32'hABCD_E008, 32'hF000_0000, 5'd1, 6'b000111);
    check("R10 srav sign", 32'hFFF0_0000, 1'b0);
    for (int i = 0; i < 100; i++) begin
      run("R9 rand sllv", $urandom, $urandom, 5'($urandom), 6'b000100);
      run("R9 rand srlv", $urandom, $urandom, 5'($urandom), 6'b000110);
      run("R9 rand srav", $urandom, $urandom, 5'($urandom), 6'b000111);
    end
  endtask

  task automatic t_unknown;
    for (int f = 0; f < 64; f++) begin
      run("R11 code sweep", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd3, 6'(f));
    end
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd7, 6'b101000);
    check("R11 unknown zero", 32'd0, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    a = '0; b = '0; sh = '0; fn = '0;
    t_idle();
    t_arith();
    t_overflow();
    t_compare();
    t_logic();
    t_shift_const();
    t_shift_var();
    t_unknown();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule